// File: doc/BRIEF.md
# Horizontal Sync Lock Monitor

This block follows a stream of horizontal sync edge strobes, one pixel clock wide, that an upstream slicer produces. It keeps a running line period and a phase reference. From these it predicts where the next sync edge should land. An edge that lands close enough to the prediction is accepted: it re-times the reference, updates the period and raises a per-line valid flag. When no accepted edge arrives, the block free-runs. It then places the reference where the edge was predicted and drops the flag.

From that reference the block drives a regenerated active-low horizontal sync pulse with a fixed width and a fixed delay. An active-low interrupt reports loss of lock. It goes low when too many lines in one field have gone without an accepted edge. A field-start strobe restarts that count.

Top module: `hsync_lock_mon`

## Requirements
- R1: An edge strobe `d` clocks after the current reference is accepted when `period-WIN <= d <= period+WIN` (both ends inclusive). `valid` is then 1 from the following clock on. `period` starts at `LINE_LEN` after reset.
- R2: If no edge is accepted by distance `period+WIN`, the block records a missed line in that clock. `valid` goes to 0 and the new reference is placed at distance `period` (free-running). Lines alternating between present and missing make `valid` toggle.
- R3: `hsync_n` falls exactly `WIN` clocks after the clock that samples an accepted edge, or after the virtual reference of a free-run line. It stays low for exactly `PULSE_W` clocks.
- R4: With edges a constant `L` clocks apart inside the window, successive falling edges of `hsync_n` are exactly `L` clocks apart.
- R5: While `valid` is 1, an edge strobe outside the window is ignored. It changes neither the pulse timing nor `valid`.
- R6: While `valid` is 0, an edge strobe outside the window re-anchors the reference to that edge without raising `valid`. A pulse follows `WIN` clocks later.
- R7: `int_n` goes low on a missed line when the number of missed lines in the current field reaches `LOST_LINES`. The count saturates there, so each further miss in the same field also drives it low.
- R8: `int_n` returns high on the next accepted edge.
- R9: `field_start` clears the missed-line count. A miss in the same clock as `field_start` is not counted.
- R10: The accepted distance is clamped to `[LINE_LEN-WIN, LINE_LEN+WIN]` before it becomes the new `period`.
- R11: After reset `hsync_n` is 1, `valid` is 0 and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset to starting state |
| sync_edge | input | 1 | One-clock strobe at each detected incoming sync falling edge |
| field_start | input | 1 | One-clock strobe at the start of each field |
| hsync_n | output | 1 | Regenerated active-low horizontal sync pulse |
| valid | output | 1 | Last line's sync edge fell inside the window |
| int_n | output | 1 | Active-low loss-of-lock interrupt |

## Verification
The interrupt is the hardest output to reach. It needs a run of lines with no accepted edge, all inside one field. It also needs a field strobe placed between misses, so that a cleared count can be told apart from a saturated one. The stimulus stops sending edges and lets the block free-run for whole lines, placing field strobes between those misses. It then re-acquires with an edge exactly one free-run period later. That edge lands in the predicted window only because the bench tracks the virtual reference. The window edges are reached by driving distances equal to the predicted period plus and minus the window, and one clock outside it.

// File: rtl/hsync_lock_mon.sv
module hsync_lock_mon #(
  parameter int LINE_LEN   = 858,
  parameter int WIN        = 16,
  parameter int PULSE_W    = 32,
  parameter int LOST_LINES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_edge,
  input  logic field_start,
  output logic hsync_n,
  output logic valid,
  output logic int_n
);
  localparam int CW = $clog2(LINE_LEN + 3*WIN + 2);
  localparam int UW = $clog2(LOST_LINES + 1);
  localparam logic [CW-1:0] WIN_C  = CW'(WIN);
  localparam logic [CW-1:0] MIN_C  = CW'(LINE_LEN - WIN);
  localparam logic [CW-1:0] MAX_C  = CW'(LINE_LEN + WIN);
  localparam logic [CW-1:0] PEND_C = CW'(WIN + PULSE_W);
  localparam logic [UW-1:0] LOST_C = UW'(LOST_LINES);

  logic [CW-1:0] cnt, period, meas;
  logic [UW-1:0] miss_cnt, miss_nxt;
  logic in_win, hit, miss, anchor;

  assign in_win = (cnt + WIN_C >= period) && (cnt <= period + WIN_C);
  assign hit    = sync_edge && in_win;
  assign anchor = sync_edge && !in_win && !valid;
  assign miss   = !hit && (cnt == period + WIN_C);
  assign meas   = (cnt < MIN_C) ? MIN_C : (cnt > MAX_C) ? MAX_C : cnt;

  assign miss_nxt = field_start ? '0 :
                    (miss && miss_cnt != LOST_C) ? miss_cnt + 1'b1 : miss_cnt;

  assign hsync_n = !((cnt > WIN_C) && (cnt <= PEND_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= PEND_C + 1'b1;
      period   <= CW'(LINE_LEN);
      valid    <= 1'b0;
      int_n    <= 1'b1;
      miss_cnt <= '0;
    end else begin
      miss_cnt <= miss_nxt;
      if (hit || anchor) cnt <= CW'(1);
      else if (miss)     cnt <= WIN_C + 1'b1;
      else               cnt <= cnt + 1'b1;
      if (hit) begin
        period <= meas;
        valid  <= 1'b1;
        int_n  <= 1'b1;
      end else if (miss) begin
        valid <= 1'b0;
        if (miss_nxt == LOST_C) int_n <= 1'b0;
      end
    end
  end

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(sync_edge));
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> !$past(sync_edge));
  p_pulse_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |=> !hsync_n);
  p_int_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> !valid);
  p_int_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> valid);
  p_miss_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cnt <= LOST_C);
  p_period_rng_r10: assert property (@(posedge clk) disable iff (!rst_n)
    period >= MIN_C && period <= MAX_C);
endmodule

// File: tb/test_hsync_lock_mon.sv
module test_hsync_lock_mon;
  localparam int LL = 100, W = 16, PW = 8, LOST = 4;

  logic clk = 0, rst_n = 0, sync_edge = 0, field_start = 0;
  logic hsync_n, valid, int_n;

  hsync_lock_mon #(.LINE_LEN(LL), .WIN(W), .PULSE_W(PW), .LOST_LINES(LOST)) i_hsync_lock_mon (
    .clk(clk), .rst_n(rst_n), .sync_edge(sync_edge), .field_start(field_start),
    .hsync_n(hsync_n), .valid(valid), .int_n(int_n));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int rf, per;
  bit done = 0, mon_on = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected fall cycles, checks pulse width
  logic prev_hs = 1;
  int last_fall = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_hs && !hsync_n) begin
        if (exp_q.size() == 0) chk("R3 unexpected pulse", cyc, -1);
        else chk("R3/R4 fall cycle", cyc, exp_q.pop_front());
        last_fall = cyc;
      end
      if (!prev_hs && hsync_n) chk("R3 width", cyc - last_fall, PW);
    end
    prev_hs = hsync_n;
  end

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic edge_at(int e, bit exp_pulse);
    wait_to(e - 1);
    sync_edge = 1;
    if (exp_pulse) exp_q.push_back(e + W);
    @(negedge clk);
    sync_edge = 0;
  endtask

  task automatic hit_line(int d);
    edge_at(rf + d, 1);
    rf += d;
    per = (d < LL - W) ? LL - W : (d > LL + W) ? LL + W : d;
  endtask

  task automatic miss_line();
    exp_q.push_back(rf + per + W);
    wait_to(rf + per + W);
    rf += per;
  endtask

  task automatic fstart();
    @(negedge clk); field_start = 1;
    @(negedge clk); field_start = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      chk("watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    chk("R11 hsync_n", hsync_n, 1);
    chk("R11 valid", valid, 0);
    chk("R11 int_n", int_n, 1);
    per = LL;
    // R6: edge while unlocked re-anchors, valid stays low
    rf = cyc + 5;
    edge_at(rf, 1);
    chk("R6 valid", valid, 0);
    hit_line(100);
    chk("R1 valid after hit", valid, 1);
    // R5: stray edge while locked
    edge_at(rf + 50, 0);
    chk("R5 valid", valid, 1);
    hit_line(100);                    // R4 spacing 100
    hit_line(110);
    chk("R1 valid +10", valid, 1);
    hit_line(126);                    // R1 upper edge, R10 clamp to 116
    chk("R1 upper edge", valid, 1);
    miss_line();                      // R10 free-run period 116
    chk("R2 valid after miss", valid, 0);
    chk("R2 int_n", int_n, 1);
    hit_line(116);
    chk("R2 toggle back", valid, 1);
    hit_line(100);                    // lower edge 116-16
    chk("R1 lower edge", valid, 1);
    edge_at(rf + 83, 0);              // R5 one clock outside
    chk("R5 outside window", valid, 1);
    miss_line();
    chk("R2 miss after outside", valid, 0);
    fstart();
    miss_line(); miss_line(); miss_line();
    chk("R7 below threshold", int_n, 1);
    miss_line();
    chk("R7 at threshold", int_n, 0);
    miss_line();
    chk("R7 stays low", int_n, 0);
    hit_line(100);
    chk("R8 int_n high", int_n, 1);
    chk("R8 valid", valid, 1);
    miss_line();
    chk("R7 saturated", int_n, 0);
    fstart();
    hit_line(100);
    chk("R8 relock", int_n, 1);
    miss_line(); miss_line(); miss_line();
    chk("R9 count cleared", int_n, 1);
    hit_line(100);
    chk("R1 final", valid, 1);
    wait_to(rf + W + PW + 5);
    chk("R3 all pulses seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule